// File: doc/BRIEF.md
# OUT Endpoint Transfer Tracker

This block keeps count of how far one programmed OUT transfer on a USB device endpoint has progressed. Software writes a single configuration word holding three fields: the number of bytes still expected, the number of packets still expected and, for control endpoints, how many SETUP packets may still arrive back to back. The word reads back at any time with the live counter values.

Three event sources move the counters. A packet pushed into the receive FIFO takes one from the packet field. A packet drained from the FIFO to system memory takes its byte count from the byte field. A received SETUP packet takes one from the SETUP field. The two counts advance at different points in the data path. Packets are counted on the way into the FIFO, and bytes on the way out. For that reason completion follows the byte side only. A drain that empties the byte field, or that carries a short packet, raises a sticky completion flag. If software programs the byte field equal to the maximum packet size, every full packet completes the transfer.

The push and drain inputs are valid/ready streams. Both ready outputs drop in any cycle in which software writes the configuration word, and an event offered in that cycle is not taken. A push or drain is accepted only in a cycle where valid and ready are both high. The source must hold valid, and for a drain also the byte count, until that cycle. The SETUP input is a plain pulse and is ignored during a write.

Top module: `out_xfer_tracker`

## Requirements
- R1: After reset the configuration word reads zero, and `xfer_done`, `cnt_err` and `setup_ovf` are low.
- R2: An accepted push lowers the packet field, which occupies bits SIZE_W+PKT_W-1 down to SIZE_W of the word, by exactly one.
- R3: An accepted drain whose byte count does not exceed the byte field lowers that field, which occupies bits SIZE_W-1:0, by the byte count.
- R4: `xfer_done` rises in the cycle after an accepted drain leaves the byte field at zero, and it stays high until the next configuration write.
- R5: Each `setup_rx` pulse outside a write lowers the SETUP field by one. The field occupies bits SIZE_W+PKT_W+SETUP_W-1 down to SIZE_W+PKT_W. A value of 1, 2 or 3 allows that many further SETUP packets.
- R6: An accepted drain of fewer than MAX_PKT bytes sets `xfer_done` even when the byte field stays non-zero.
- R7: An accepted push while the packet field is zero leaves the field at zero. An accepted drain of more bytes than remain sets the byte field to zero and also sets `xfer_done`. Either event sets the sticky flag `cnt_err`.
- R8: A `setup_rx` pulse outside a write while the SETUP field is zero leaves the field at zero and sets the sticky flag `setup_ovf`.
- R9: A configuration write loads all three fields from `cfg_wdata` at the positions above and clears `xfer_done`, `cnt_err` and `setup_ovf`. The result is visible in the next cycle. The top bit of the word always reads zero.
- R10: While `cfg_wr` is high, `push_ready` and `drain_ready` are low, and push, drain and SETUP events have no effect. Otherwise both ready outputs are high.
- R11: With the byte field loaded with MAX_PKT, a single drain of MAX_PKT bytes completes the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | REG_W | Configuration word to load |
| cfg_rdata | output | REG_W | Live configuration word |
| push_valid | input | 1 | A packet is being written into the receive FIFO |
| push_ready | output | 1 | Push can be taken this cycle |
| setup_rx | input | 1 | A SETUP packet was received (pulse) |
| drain_valid | input | 1 | A packet is being moved from the FIFO to memory |
| drain_ready | output | 1 | Drain can be taken this cycle |
| drain_bytes | input | BYTE_W | Byte count of the drained packet |
| xfer_done | output | 1 | Sticky transfer-complete interrupt |
| cnt_err | output | 1 | Sticky counter underflow flag |
| setup_ovf | output | 1 | Sticky SETUP overflow flag |

## Verification
The bench builds the block with SIZE_W=10, PKT_W=4, SETUP_W=2 and MAX_PKT=8. This makes the configuration word 17 bits wide and the byte count 4 bits wide. A 4-bit packet field and an 8-byte maximum packet let random traffic often drive every counter to zero and past it. Drains of exactly MAX_PKT bytes and of short lengths both occur often, so the full-packet and short-packet completion rules are exercised alongside the R7 underflow and R8 overflow paths.

// File: rtl/oxt_pkg.sv
package oxt_pkg;

  typedef struct packed {
    logic done;
    logic err;
    logic ovf;
  } oxt_flags_t;

  // Bits needed to hold values 0..v inclusive.
  function automatic int count_width(input int v);
    int w;
    w = 1;
    for (int i = 1; i < 31; i++) begin
      if ((1 << w) <= v) w = w + 1;
    end
    return w;
  endfunction

endpackage

// File: rtl/sat_down_ctr.sv
module sat_down_ctr #(
  parameter int W      = 8,
  parameter int STEP_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  input  logic              dec,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      count,
  output logic              under,
  output logic              reach_zero
);
  localparam int CW = (W > STEP_W) ? W : STEP_W;

  logic [CW-1:0] cnt_x;
  logic [CW-1:0] step_x;
  logic          too_big;
  logic          covers;

  assign cnt_x   = CW'(count);
  assign step_x  = CW'(step);
  assign too_big = step_x > cnt_x;
  assign covers  = step_x >= cnt_x;

  assign under      = dec & too_big;
  assign reach_zero = dec & covers;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec) begin
      if (covers) count <= '0;
      else        count <= count - W'(step_x);
    end
  end
endmodule

// File: rtl/oxt_status.sv
module oxt_status
  import oxt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       set_done,
  input  logic       set_err,
  input  logic       set_ovf,
  output oxt_flags_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (clear) begin
      flags <= '0;
    end else begin
      if (set_done) flags.done <= 1'b1;
      if (set_err)  flags.err  <= 1'b1;
      if (set_ovf)  flags.ovf  <= 1'b1;
    end
  end
endmodule

// File: rtl/out_xfer_tracker.sv
module out_xfer_tracker
  import oxt_pkg::*;
#(
  parameter int SIZE_W  = 19,
  parameter int PKT_W   = 10,
  parameter int SETUP_W = 2,
  parameter int MAX_PKT = 64,
  localparam int REG_W  = SIZE_W + PKT_W + SETUP_W + 1,
  localparam int BYTE_W = oxt_pkg::count_width(MAX_PKT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic              setup_rx,
  input  logic              drain_valid,
  output logic              drain_ready,
  input  logic [BYTE_W-1:0] drain_bytes,
  output logic              xfer_done,
  output logic              cnt_err,
  output logic              setup_ovf
);
  localparam int PKT_LSB   = SIZE_W;
  localparam int SETUP_LSB = SIZE_W + PKT_W;

  logic               push_fire, drain_fire, setup_fire;
  logic [SIZE_W-1:0]  size_q;
  logic [PKT_W-1:0]   pkt_q;
  logic [SETUP_W-1:0] setup_q;
  logic               size_under, size_zero;
  logic               pkt_under, pkt_zero_unused;
  logic               setup_under, setup_zero_unused;
  logic               short_pkt;
  oxt_flags_t         flags;

  // A write owns the cycle: streams are stalled and pulses dropped.
  assign push_ready  = ~cfg_wr;
  assign drain_ready = ~cfg_wr;
  assign push_fire   = push_valid & push_ready;
  assign drain_fire  = drain_valid & drain_ready;
  assign setup_fire  = setup_rx & ~cfg_wr;

  sat_down_ctr #(.W(SIZE_W), .STEP_W(BYTE_W)) u_bytes (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_wr),
    .load_val   (cfg_wdata[SIZE_W-1:0]),
    .dec        (drain_fire),
    .step       (drain_bytes),
    .count      (size_q),
    .under      (size_under),
    .reach_zero (size_zero)
  );

  sat_down_ctr #(.W(PKT_W), .STEP_W(1)) u_pkts (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_wr),
    .load_val   (cfg_wdata[PKT_LSB +: PKT_W]),
    .dec        (push_fire),
    .step       (1'b1),
    .count      (pkt_q),
    .under      (pkt_under),
    .reach_zero (pkt_zero_unused)
  );

  sat_down_ctr #(.W(SETUP_W), .STEP_W(1)) u_setup (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cfg_wr),
    .load_val   (cfg_wdata[SETUP_LSB +: SETUP_W]),
    .dec        (setup_fire),
    .step       (1'b1),
    .count      (setup_q),
    .under      (setup_under),
    .reach_zero (setup_zero_unused)
  );

  assign short_pkt = drain_bytes < BYTE_W'(MAX_PKT);

  oxt_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg_wr),
    .set_done (drain_fire & (size_zero | short_pkt)),
    .set_err  (pkt_under | size_under),
    .set_ovf  (setup_under),
    .flags    (flags)
  );

  assign cfg_rdata = {1'b0, setup_q, pkt_q, size_q};
  assign xfer_done = flags.done;
  assign cnt_err   = flags.err;
  assign setup_ovf = flags.ovf;

  // Reach-zero outputs of the unit-step counters are not needed here.
  logic unused_ok;
  assign unused_ok = pkt_zero_unused ^ setup_zero_unused;
endmodule

// File: rtl/oxt_checker.sv
module oxt_checker #(
  parameter int SIZE_W  = 19,
  parameter int PKT_W   = 10,
  parameter int SETUP_W = 2,
  parameter int MAX_PKT = 64,
  localparam int REG_W  = SIZE_W + PKT_W + SETUP_W + 1,
  localparam int BYTE_W = oxt_pkg::count_width(MAX_PKT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              push_valid,
  input logic              push_ready,
  input logic              setup_rx,
  input logic              drain_valid,
  input logic              drain_ready,
  input logic [BYTE_W-1:0] drain_bytes,
  input logic              xfer_done,
  input logic              cnt_err,
  input logic              setup_ovf
);
  localparam int PKT_LSB   = SIZE_W;
  localparam int SETUP_LSB = SIZE_W + PKT_W;

  logic [SIZE_W-1:0]  c_size;
  logic [PKT_W-1:0]   c_pkt;
  logic [SETUP_W-1:0] c_setup;
  assign c_size  = cfg_rdata[SIZE_W-1:0];
  assign c_pkt   = cfg_rdata[PKT_LSB +: PKT_W];
  assign c_setup = cfg_rdata[SETUP_LSB +: SETUP_W];

  assert_stall_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (!push_ready && !drain_ready));

  assert_pkt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && c_pkt != '0) |=> (c_pkt == $past(c_pkt) - 1'b1));

  assert_byte_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && drain_ready && SIZE_W'(drain_bytes) <= c_size)
      |=> (c_size == $past(c_size) - SIZE_W'($past(drain_bytes))));

  assert_pkt_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && c_pkt == '0) |=> (cnt_err && c_pkt == '0));

  assert_setup_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_rx && !cfg_wr && c_setup == '0) |=> (setup_ovf && c_setup == '0));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cfg_wr) |=> xfer_done);

  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == {1'b0, $past(cfg_wdata[REG_W-2:0])}
                && !xfer_done && !cnt_err && !setup_ovf));
endmodule

bind out_xfer_tracker oxt_checker #(
  .SIZE_W (SIZE_W),
  .PKT_W  (PKT_W),
  .SETUP_W(SETUP_W),
  .MAX_PKT(MAX_PKT)
) u_oxt_checker (.*);

// File: tb/tb_out_xfer_tracker.sv
module tb_out_xfer_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 10;
  localparam int PW = 4;
  localparam int STW = 2;
  localparam int MP = 8;
  localparam int RW = SW + PW + STW + 1;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic          push_valid = 1'b0, push_ready;
  logic          setup_rx = 1'b0;
  logic          drain_valid = 1'b0, drain_ready;
  logic [BW-1:0] drain_bytes = '0;
  logic          xfer_done, cnt_err, setup_ovf;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference model state
  int m_size = 0, m_pkt = 0, m_setup = 0;
  bit m_done = 0, m_err = 0, m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  out_xfer_tracker #(.SIZE_W(SW), .PKT_W(PW), .SETUP_W(STW), .MAX_PKT(MP)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .push_valid(push_valid), .push_ready(push_ready),
    .setup_rx(setup_rx), .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_bytes(drain_bytes), .xfer_done(xfer_done), .cnt_err(cnt_err),
    .setup_ovf(setup_ovf)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_size = 0; m_pkt = 0; m_setup = 0;
      m_done = 0; m_err = 0; m_ovf = 0;
    end else if (cfg_wr) begin
      m_size  = int'(cfg_wdata) % (1 << SW);
      m_pkt   = (int'(cfg_wdata) >> SW) % (1 << PW);
      m_setup = (int'(cfg_wdata) >> (SW + PW)) % (1 << STW);
      m_done = 0; m_err = 0; m_ovf = 0;
    end else begin
      if (push_valid) begin
        if (m_pkt == 0) m_err = 1; else m_pkt = m_pkt - 1;
      end
      if (setup_rx) begin
        if (m_setup == 0) m_ovf = 1; else m_setup = m_setup - 1;
      end
      if (drain_valid) begin
        int b;
        b = int'(drain_bytes);
        if (b > m_size) begin
          m_err = 1; m_size = 0;
        end else begin
          m_size = m_size - b;
        end
        if (m_size == 0 || b < MP) m_done = 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every output against the model; `ovr` renames the requirement tag.
  task automatic compare(input string ovr);
    vectors++;
    chk(ovr == "" ? "R3" : ovr, "bytes", int'(cfg_rdata[SW-1:0]), m_size);
    chk(ovr == "" ? "R2" : ovr, "packets", int'(cfg_rdata[SW +: PW]), m_pkt);
    chk(ovr == "" ? "R5" : ovr, "setup", int'(cfg_rdata[SW+PW +: STW]), m_setup);
    chk(ovr == "" ? "R9" : ovr, "top bit", int'(cfg_rdata[RW-1]), 0);
    chk(ovr == "" ? "R4" : ovr, "xfer_done", int'(xfer_done), int'(m_done));
    chk(ovr == "" ? "R7" : ovr, "cnt_err", int'(cnt_err), int'(m_err));
    chk(ovr == "" ? "R8" : ovr, "setup_ovf", int'(setup_ovf), int'(m_ovf));
    chk(ovr == "" ? "R10" : ovr, "push_ready", int'(push_ready), int'(!cfg_wr));
    chk(ovr == "" ? "R10" : ovr, "drain_ready", int'(drain_ready), int'(!cfg_wr));
  endtask

  function automatic logic [RW-1:0] word(input int sz, input int pk, input int st);
    return RW'((st << (SW + PW)) | (pk << SW) | sz);
  endfunction

  // Drive one cycle at the falling edge, then compare at the next falling edge.
  task automatic cyc(input string req, input bit wr, input logic [RW-1:0] wd,
                     input bit pu, input bit su, input bit dr, input int by);
    cfg_wr = wr; cfg_wdata = wd; push_valid = pu; setup_rx = su;
    drain_valid = dr; drain_bytes = BW'(by);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");                                  // R1 reset state
    rst_n = 1'b1;
    @(negedge clk); compare("R1");

    cyc("R9", 1, word(20, 3, 2), 0, 0, 0, 0);       // R9 load fields
    cyc("R2", 0, '0, 1, 0, 0, 0);                   // R2 packet steps
    cyc("R2", 0, '0, 1, 0, 0, 0);
    cyc("R2", 0, '0, 1, 0, 0, 0);
    cyc("R7", 0, '0, 1, 0, 0, 0);                   // R7 push at zero
    cyc("R3", 0, '0, 0, 0, 1, 8);                   // R3 full packet 20->12
    cyc("R6", 0, '0, 0, 0, 1, 3);                   // R6 short packet completes
    cyc("R5", 0, '0, 0, 1, 0, 0);                   // R5 setup 2->1
    cyc("R5", 0, '0, 0, 1, 0, 0);                   // R5 setup 1->0
    cyc("R8", 0, '0, 0, 1, 0, 0);                   // R8 overflow
    cyc("R9", 1, word(MP, 5, 3), 0, 0, 0, 0);       // R9 flags cleared
    cyc("R11", 0, '0, 0, 0, 1, MP);                 // R11 MPS-size transfer done
    cyc("R4", 0, '0, 0, 0, 0, 0);                   // R4 done stays
    cyc("R10", 1, word(30, 2, 1), 1, 1, 1, 8);      // R10 events during write ignored
    cyc("R10", 0, '0, 0, 0, 0, 0);
    cyc("R4", 0, '0, 0, 0, 1, 8);                   // R4 30->22, no done
    cyc("R4", 0, '0, 0, 0, 1, 8);
    cyc("R4", 0, '0, 0, 0, 1, 8);
    cyc("R7", 0, '0, 0, 0, 1, 8);                   // R7 overdrain 6 left
    cyc("R7", 0, '0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      bit wr;
      wr = ($urandom_range(0, 19) == 0);
      cyc("", wr, RW'($urandom), $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, MP));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule